// File: doc/BRIEF.md
# Branch Delay Slot Sequencer

This block steers the next-fetch address of an in-order core whose branch instructions can carry an architectural delay slot. Each cycle the issue stage presents a decoded instruction class, the current value of the condition flag and an already computed branch target. The sequencer decides whether control moves at once, moves after one more instruction, or does not move, and it drives the next-fetch address to match.

Unconditional jumps, the always-branch, both call forms, and both returns are delayed. So are the conditional branches with a slot. For these the target is captured when the branch issues. The following instruction then issues from the sequential address, and the captured target is applied once that slot instruction issues. The plain conditional branches have no slot. When one is taken, the sequencer raises a one-cycle flush that discards the instruction fetched behind it and redirects at once. A branch that issues in a delay slot is reported as illegal and produces no second redirect. Loaded values need no interlock, so the block has no stall logic of its own: a cycle without a valid instruction simply holds its state.

Top module: `bds_seq`

## Requirements
- R1: While reset is asserted and right after it, fetchPc equals RESET_PC and flushNext, slotIllegal and slotPending are all 0.
- R2: An issued instruction that is not a branch (class 0, or any class code 11 to 15) advances fetchPc by INST_BYTES on the next clock. A cycle with instValid low leaves fetchPc and slotPending unchanged.
- R3: The always-delayed classes are jump (1), always-branch (2), immediate call (3), register-relative call (4), subroutine return (5) and exception return (6). When one of these issues with no slot pending, fetchPc advances by INST_BYTES and slotPending rises on the next clock. When the slot instruction issues, fetchPc takes the captured target and slotPending falls.
- R4: The target used after a delay slot is the targetAddr value sampled when the branch issued. targetAddr during the slot has no effect.
- R5: Branch-if-true-with-slot (9) is taken when tFlag=1 and branch-if-false-with-slot (10) is taken when tFlag=0. A taken one behaves as in R3.
- R6: A slotted conditional branch that is not taken advances fetchPc by INST_BYTES and leaves slotPending at 0.
- R7: Branch-if-true (7) with tFlag=1, or branch-if-false (8) with tFlag=0, raises flushNext in its issue cycle. fetchPc equals targetAddr on the next clock, and slotPending stays 0.
- R8: Branch-if-true with tFlag=0, or branch-if-false with tFlag=1, leaves flushNext at 0 and advances fetchPc by INST_BYTES.
- R9: A branch of any class 1 to 10 that issues while slotPending is 1 raises slotIllegal in that cycle. It raises no flush and is not followed by a redirect of its own: fetchPc still takes the first branch's target.
- R10: While a slot is pending, cycles with instValid low keep slotPending at 1 and fetchPc unchanged. The redirect happens only when a valid slot instruction issues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| instValid | input | 1 | An instruction issues this cycle |
| instClass | input | 4 | Decoded branch class code of the issuing instruction |
| tFlag | input | 1 | Condition flag tested by conditional branches |
| targetAddr | input | ADDR_W | Computed branch target of the issuing instruction |
| fetchPc | output | ADDR_W | Next-fetch address |
| flushNext | output | 1 | Discard the instruction fetched behind a taken non-slotted branch |
| slotIllegal | output | 1 | A branch issued inside a delay slot |
| slotPending | output | 1 | A delayed redirect waits for its slot instruction |

## Verification
Every delayed class is issued in turn, and each is followed by a slot instruction carrying a different target. This separates an applied latched target from one sampled late, and it shows that the redirect waits one instruction. The four conditional classes are issued under both flag values, which separates slotted from non-slotted handling and taken from not-taken. Idle cycles placed inside a pending slot, and branches placed inside a slot, probe the stall hold and the illegal-slot path. The illegal-slot path must keep the first target and raise no flush.

// File: rtl/bds_pkg.sv
`timescale 1ns/1ps
package bds_pkg;

  typedef enum logic [3:0] {
    CLS_OTHER      = 4'd0,
    CLS_JUMP       = 4'd1,
    CLS_BR_ALWAYS  = 4'd2,
    CLS_CALL_IMM   = 4'd3,
    CLS_CALL_REG   = 4'd4,
    CLS_RET_SUB    = 4'd5,
    CLS_RET_EXC    = 4'd6,
    CLS_BR_TRUE    = 4'd7,
    CLS_BR_FALSE   = 4'd8,
    CLS_BR_TRUE_S  = 4'd9,
    CLS_BR_FALSE_S = 4'd10
  } branchClass_e;

  // strobes from control to datapath
  typedef struct packed {
    logic advance;      // fetchPc <= fetchPc + step
    logic takeTarget;   // fetchPc <= targetAddr (immediate redirect)
    logic takeLatched;  // fetchPc <= captured target (end of slot)
    logic latchTarget;  // capture targetAddr for a later redirect
  } seqStrobes_t;

  function automatic logic isAlwaysDelayed(input logic [3:0] c);
    return (c >= 4'd1) && (c <= 4'd6);
  endfunction

  function automatic logic isBranch(input logic [3:0] c);
    return (c >= 4'd1) && (c <= 4'd10);
  endfunction

endpackage

// File: rtl/bds_ctrl.sv
`timescale 1ns/1ps
module bds_ctrl
  import bds_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        instValid,
  input  logic [3:0]  instClass,
  input  logic        tFlag,
  output seqStrobes_t strobes,
  output logic        flushNext,
  output logic        slotIllegal,
  output logic        slotPending
);

  logic condMet;
  logic delayedTaken;
  logic directTaken;
  logic pendingNext;

  // condition evaluation: true-variants test tFlag=1, false-variants tFlag=0
  always_comb begin
    unique case (instClass)
      CLS_BR_TRUE, CLS_BR_TRUE_S:   condMet = tFlag;
      CLS_BR_FALSE, CLS_BR_FALSE_S: condMet = ~tFlag;
      default:                      condMet = 1'b0;
    endcase
  end

  always_comb begin
    delayedTaken = isAlwaysDelayed(instClass) ||
                   (((instClass == CLS_BR_TRUE_S) || (instClass == CLS_BR_FALSE_S)) && condMet);
    directTaken  = ((instClass == CLS_BR_TRUE) || (instClass == CLS_BR_FALSE)) && condMet;
  end

  always_comb begin
    strobes     = '0;
    flushNext   = 1'b0;
    slotIllegal = 1'b0;
    pendingNext = slotPending;
    if (instValid) begin
      if (slotPending) begin
        // slot instruction issues: apply the captured redirect only
        strobes.takeLatched = 1'b1;
        slotIllegal         = isBranch(instClass);
        pendingNext         = 1'b0;
      end else if (directTaken) begin
        strobes.takeTarget = 1'b1;
        flushNext          = 1'b1;
      end else if (delayedTaken) begin
        strobes.latchTarget = 1'b1;
        strobes.advance     = 1'b1;
        pendingNext         = 1'b1;
      end else begin
        strobes.advance = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) slotPending <= 1'b0;
    else       slotPending <= pendingNext;
  end

endmodule

// File: rtl/bds_datapath.sv
`timescale 1ns/1ps
module bds_datapath
  import bds_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned INST_BYTES = 2,
  parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobes_t       strobes,
  input  logic [ADDR_W-1:0] targetAddr,
  output logic [ADDR_W-1:0] fetchPc
);

  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INST_BYTES);

  logic [ADDR_W-1:0] heldTarget;
  logic [ADDR_W-1:0] seqPc;

  assign seqPc = fetchPc + STEP;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fetchPc <= RESET_PC;
    end else if (strobes.takeLatched) begin
      fetchPc <= heldTarget;
    end else if (strobes.takeTarget) begin
      fetchPc <= targetAddr;
    end else if (strobes.advance) begin
      fetchPc <= seqPc;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                    heldTarget <= '0;
    else if (strobes.latchTarget) heldTarget <= targetAddr;
  end

endmodule

// File: rtl/bds_seq.sv
`timescale 1ns/1ps
module bds_seq
  import bds_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned INST_BYTES = 2,
  parameter logic [ADDR_W-1:0] RESET_PC = ADDR_W'(32'h0000_1000)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              instValid,
  input  logic [3:0]        instClass,
  input  logic              tFlag,
  input  logic [ADDR_W-1:0] targetAddr,
  output logic [ADDR_W-1:0] fetchPc,
  output logic              flushNext,
  output logic              slotIllegal,
  output logic              slotPending
);

  seqStrobes_t strobes;

  bds_ctrl ctrl_i (
    .clk         (clk),
    .rstN        (rstN),
    .instValid   (instValid),
    .instClass   (instClass),
    .tFlag       (tFlag),
    .strobes     (strobes),
    .flushNext   (flushNext),
    .slotIllegal (slotIllegal),
    .slotPending (slotPending)
  );

  bds_datapath #(
    .ADDR_W     (ADDR_W),
    .INST_BYTES (INST_BYTES),
    .RESET_PC   (RESET_PC)
  ) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .targetAddr (targetAddr),
    .fetchPc    (fetchPc)
  );

endmodule

// File: rtl/bds_seq_chk.sv
`timescale 1ns/1ps
module bds_seq_chk #(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned INST_BYTES = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              instValid,
  input logic [3:0]        instClass,
  input logic              tFlag,
  input logic [ADDR_W-1:0] targetAddr,
  input logic [ADDR_W-1:0] fetchPc,
  input logic              flushNext,
  input logic              slotIllegal,
  input logic              slotPending
);

  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INST_BYTES);

  // R7: an immediate redirect lands on the target seen in the flush cycle
  a_r7_flush_redirect: assert property (@(posedge clk) disable iff (!rstN)
    flushNext |=> (fetchPc == $past(targetAddr)) && !slotPending);

  // R3: an always-delayed class opens a slot
  a_r3_slot_opens: assert property (@(posedge clk) disable iff (!rstN)
    (instValid && !slotPending && (instClass >= 4'd1) && (instClass <= 4'd6))
      |=> slotPending && (fetchPc == $past(fetchPc) + STEP));

  // R6: untaken slotted conditional continues in sequence
  a_r6_untaken_seq: assert property (@(posedge clk) disable iff (!rstN)
    (instValid && !slotPending &&
     (((instClass == 4'd9) && !tFlag) || ((instClass == 4'd10) && tFlag)))
      |=> !slotPending && (fetchPc == $past(fetchPc) + STEP));

  // R9: illegal flag only inside a slot, and never together with a flush
  a_r9_illegal_in_slot: assert property (@(posedge clk) disable iff (!rstN)
    slotIllegal |-> slotPending && !flushNext);

  // R9: no flush while a slot is pending
  a_r9_no_flush_in_slot: assert property (@(posedge clk) disable iff (!rstN)
    slotPending |-> !flushNext);

  // R2 / R10: idle cycles hold state
  a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    !instValid |=> $stable(fetchPc) && $stable(slotPending));

  // R10: a valid slot instruction closes the slot
  a_r10_slot_closes: assert property (@(posedge clk) disable iff (!rstN)
    (instValid && slotPending) |=> !slotPending);

endmodule

bind bds_seq bds_seq_chk #(
  .ADDR_W     (ADDR_W),
  .INST_BYTES (INST_BYTES)
) chk_i (
  .clk         (clk),
  .rstN        (rstN),
  .instValid   (instValid),
  .instClass   (instClass),
  .tFlag       (tFlag),
  .targetAddr  (targetAddr),
  .fetchPc     (fetchPc),
  .flushNext   (flushNext),
  .slotIllegal (slotIllegal),
  .slotPending (slotPending)
);

// File: tb/bds_seq_tb.sv
`timescale 1ns/1ps
module bds_seq_tb_top;

  localparam logic [31:0] RST_PC = 32'h0000_1000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        instValid = 1'b0;
  logic [3:0]  instClass = 4'd0;
  logic        tFlag = 1'b0;
  logic [31:0] targetAddr = '0;
  logic [31:0] fetchPc;
  logic        flushNext, slotIllegal, slotPending;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // bench reference model
  logic [31:0] mPc = RST_PC;
  logic        mPend = 1'b0;
  logic [31:0] mTgt = '0;

  logic [31:0] qPc[$];
  logic        qPend[$];
  string       qTag[$];

  always #2 clk = ~clk;

  bds_seq dut_i (
    .clk(clk), .rstN(rstN), .instValid(instValid), .instClass(instClass),
    .tFlag(tFlag), .targetAddr(targetAddr), .fetchPc(fetchPc),
    .flushNext(flushNext), .slotIllegal(slotIllegal), .slotPending(slotPending)
  );

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic slotted(input logic [3:0] c, input logic t);
    return (c >= 4'd1 && c <= 4'd6) || (c == 4'd9 && t) || (c == 4'd10 && !t);
  endfunction

  function automatic logic direct(input logic [3:0] c, input logic t);
    return (c == 4'd7 && t) || (c == 4'd8 && !t);
  endfunction

  // driver: one cycle of stimulus, same-cycle checks, expected next state queued
  task automatic step(input logic v, input logic [3:0] c, input logic t,
                      input logic [31:0] tg, input string tag);
    logic isBr;
    @(negedge clk);
    instValid = v; instClass = c; tFlag = t; targetAddr = tg;
    #1;
    isBr = (c >= 4'd1 && c <= 4'd10);
    check(tag, "flushNext",   32'(flushNext),   32'(v && !mPend && direct(c, t)));
    check(tag, "slotIllegal", 32'(slotIllegal), 32'(v && mPend && isBr));
    if (v) begin
      if (mPend) begin
        mPc = mTgt; mPend = 1'b0;
      end else if (direct(c, t)) begin
        mPc = tg;
      end else if (slotted(c, t)) begin
        mPc = mPc + 32'd2; mPend = 1'b1; mTgt = tg;
      end else begin
        mPc = mPc + 32'd2;
      end
    end
    qPc.push_back(mPc); qPend.push_back(mPend); qTag.push_back(tag);
  endtask

  // monitor: compares registered outputs after each edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (qPc.size() > 0) begin
        logic [31:0] ePc;
        logic        ePend;
        string       eTag;
        ePc = qPc.pop_front(); ePend = qPend.pop_front(); eTag = qTag.pop_front();
        check(eTag, "fetchPc", fetchPc, ePc);
        check(eTag, "slotPending", 32'(slotPending), 32'(ePend));
      end
    end
  end

  // watchdog
  initial begin
    #400000;
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "fetchPc in reset", fetchPc, RST_PC);
    rstN = 1'b1;
    @(negedge clk); #1;
    check("R1", "fetchPc", fetchPc, RST_PC);
    check("R1", "flushNext", 32'(flushNext), 32'd0);
    check("R1", "slotIllegal", 32'(slotIllegal), 32'd0);
    check("R1", "slotPending", 32'(slotPending), 32'd0);

    // R2: sequential flow, reserved codes, idle hold
    step(1, 4'd0, 0, 32'h0000_9000, "R2");
    step(1, 4'd13, 1, 32'h0000_9100, "R2");
    step(0, 4'd2, 0, 32'h0000_9200, "R2");
    step(1, 4'd0, 0, 32'h0, "R2");

    // R3 / R4: every always-delayed class, slot carries a decoy target
    for (int c = 1; c <= 6; c++) begin
      step(1, 4'(c), c[0], 32'h0000_2000 + 32'(c) * 32'h100, "R3");
      step(1, 4'd0, 0, 32'hDEAD_0000 + 32'(c), "R4");
      step(1, 4'd0, 0, 32'h0, "R3");
    end

    // R5: slotted conditional taken
    step(1, 4'd9, 1, 32'h0000_3000, "R5");
    step(1, 4'd0, 1, 32'h0000_5555, "R5");
    step(1, 4'd10, 0, 32'h0000_3400, "R5");
    step(1, 4'd0, 0, 32'h0000_6666, "R5");

    // R6: slotted conditional not taken
    step(1, 4'd9, 0, 32'h0000_3800, "R6");
    step(1, 4'd0, 0, 32'h0, "R6");
    step(1, 4'd10, 1, 32'h0000_3C00, "R6");
    step(1, 4'd0, 0, 32'h0, "R6");

    // R7: non-slotted taken
    step(1, 4'd7, 1, 32'h0000_4000, "R7");
    step(1, 4'd0, 1, 32'h0, "R7");
    step(1, 4'd8, 0, 32'h0000_4400, "R7");
    step(1, 4'd0, 0, 32'h0, "R7");

    // R8: non-slotted not taken
    step(1, 4'd7, 0, 32'h0000_4800, "R8");
    step(1, 4'd8, 1, 32'h0000_4C00, "R8");

    // R9: branches inside a slot
    step(1, 4'd2, 0, 32'h0000_5000, "R9");
    step(1, 4'd7, 1, 32'h0000_7700, "R9");
    step(1, 4'd0, 0, 32'h0, "R9");
    step(1, 4'd1, 0, 32'h0000_5400, "R9");
    step(1, 4'd3, 0, 32'h0000_7800, "R9");
    step(1, 4'd0, 0, 32'h0, "R9");
    step(1, 4'd9, 1, 32'h0000_5800, "R9");
    step(1, 4'd10, 0, 32'h0000_7900, "R9");
    step(1, 4'd0, 0, 32'h0, "R9");

    // R10: stall inside a pending slot
    step(1, 4'd5, 0, 32'h0000_6000, "R10");
    step(0, 4'd0, 0, 32'h0000_6A00, "R10");
    step(0, 4'd7, 1, 32'h0000_6B00, "R10");
    step(1, 4'd0, 0, 32'h0000_6C00, "R10");
    step(1, 4'd0, 0, 32'h0, "R10");

    @(negedge clk);
    instValid = 1'b0;
    repeat (3) @(negedge clk);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule